// File: doc/BRIEF.md
# Region Protection and Translation Unit

This block guards and translates every memory access of a 32-bit core that has no paging hardware. The address space is cut into eight fixed regions of 512 MB each, chosen directly by the three most significant address bits, so no associative search is involved. Each region holds a 3-bit physical base and a 4-bit attribute code. Instruction fetches are checked against one table of regions and loads and stores against a second, independent table.

For each request the unit decodes the selected region's attribute into read, write and execute rights. It then checks the requested access kind against those rights. It returns either the translated physical address or a cause code that names the kind of access that was refused. The mapping from attribute to rights does not rise steadily with the code: value 3 gives execute without read or write, and value 14 gives read and write outside the low band.

The lookup result is available in the same cycle as the request, and a registered copy with a valid flag follows one cycle later for pipelined use. A single update port rewrites one region of either table, and the new contents take effect from the next cycle on.

Top module: `rgn_prot_unit`

## Requirements
- R1: The region index is request address bits 31:29. The physical address is {region physical base, request address bits 28:0}.
- R2: Read and write are both granted when the attribute is below 6 and not equal to 3, or when it equals 14. Every other attribute denies read and write.
- R3: Execute is granted only for attribute values 1, 2, 3, 4 and 5.
- R4: Kind 2 (fetch) uses the instruction table. Kinds 0 (load), 1 (store) and 3 use the data table.
- R5: A denied request drives lk_deny_o high with cause code 1 for a fetch, 2 for a load and 3 for a store. A granted request gives lk_deny_o low and cause 0.
- R6: After reset, region i of both tables has physical base i (identity map) and attribute 2.
- R7: A write through the update port changes only the addressed region of the selected table (upd_tbl_i 0 = data, 1 = instruction). A lookup in the same cycle as the write still sees the old contents, and lookups from the next cycle on see the new contents.
- R8: rsp_valid_o is req_valid_i delayed by one cycle. The rsp_* fields carry the previous cycle's lookup result when that request was valid, and otherwise hold their values.
- R9: pg_size_o always reports the region size 2^29.
- R10: Access kind 3 is reserved. It is always denied with cause 2.
- R11: lk_rights_o reports the rights of the selected region as {execute, write, read} in bits 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid, copied into the registered response |
| req_vaddr_i | input | 32 | Virtual address of the request |
| req_kind_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| upd_en_i | input | 1 | Region update enable |
| upd_tbl_i | input | 1 | Table to update: 0 data, 1 instruction |
| upd_idx_i | input | 3 | Region to update |
| upd_pbase_i | input | 3 | New physical base (upper address bits) |
| upd_attr_i | input | 4 | New attribute code |
| lk_paddr_o | output | 32 | Combinational translated address |
| lk_deny_o | output | 1 | Combinational access-refused flag |
| lk_cause_o | output | 2 | Combinational cause code (0 none, 1 fetch, 2 load, 3 store) |
| lk_rights_o | output | 3 | Combinational rights {x, w, r} of the selected region |
| pg_size_o | output | 32 | Region size in bytes |
| rsp_valid_o | output | 1 | Registered response valid |
| rsp_paddr_o | output | 32 | Registered translated address |
| rsp_deny_o | output | 1 | Registered refused flag |
| rsp_cause_o | output | 2 | Registered cause code |

## Verification
The lk_* outputs depend on the request in the same cycle. They are sampled a short delay after the request is driven on the falling edge, well before the next rising edge. The registered rsp_* outputs are due one rising edge later. The driver pushes each predicted response into a queue, and a monitor pops it on the following falling edge and compares it. A region update is probed in its own cycle against the old table contents and in later cycles against the new contents, which pins the one-cycle latency of the write port.

// File: rtl/rgn_prot_pkg.sv
package rgn_prot_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      CZ_NONE  = 2'd0,
      CZ_FETCH = 2'd1,
      CZ_LOAD  = 2'd2,
      CZ_STORE = 2'd3
   } deny_cause_e;

   typedef struct packed {
      logic x;
      logic w;
      logic r;
   } rights_t;

   localparam int TBL_DATA  = 0;
   localparam int TBL_INSTR = 1;
   localparam int NUM_TBL   = 2;

endpackage

// File: rtl/rgn_attr_decode.sv
module rgn_attr_decode
   import rgn_prot_pkg::*;
#(
   parameter int ATTR_W = 4
) (
   input  logic [ATTR_W-1:0] attr_i,
   output rights_t           rights_o
);

   localparam logic [ATTR_W-1:0] RW_LIMIT  = ATTR_W'(6);
   localparam logic [ATTR_W-1:0] RW_HOLE   = ATTR_W'(3);
   localparam logic [ATTR_W-1:0] RW_EXTRA  = ATTR_W'(14);
   localparam logic [ATTR_W-1:0] X_LOW     = ATTR_W'(1);
   localparam logic [ATTR_W-1:0] X_HIGH    = ATTR_W'(5);

   generate
      if (ATTR_W < 4) begin : g_bad_w
         $error("rgn_attr_decode: ATTR_W must be at least 4");
      end
   endgenerate

   logic rw_ok;
   logic x_ok;

   always_comb begin
      rw_ok = ((attr_i < RW_LIMIT) && (attr_i != RW_HOLE)) || (attr_i == RW_EXTRA);
      x_ok  = (attr_i >= X_LOW) && (attr_i <= X_HIGH);
      rights_o.r = rw_ok;
      rights_o.w = rw_ok;
      rights_o.x = x_ok;
   end

endmodule

// File: rtl/rgn_table.sv
module rgn_table #(
   parameter int IDX_W    = 3,
   parameter int ATTR_W   = 4,
   parameter int RST_ATTR = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [IDX_W-1:0]  wpb_i,
   input  logic [ATTR_W-1:0] wat_i,
   input  logic [IDX_W-1:0]  ridx_i,
   output logic [IDX_W-1:0]  rpb_o,
   output logic [ATTR_W-1:0] rat_o
);

   localparam int NREG = 1 << IDX_W;

   generate
      if (RST_ATTR >= (1 << ATTR_W)) begin : g_bad_rst
         $error("rgn_table: RST_ATTR does not fit ATTR_W");
      end
   endgenerate

   logic [IDX_W-1:0]  pb_arr [NREG];
   logic [ATTR_W-1:0] at_arr [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_rgn
      logic [IDX_W-1:0]  pb_q;
      logic [ATTR_W-1:0] at_q;
      logic              hit;

      assign hit = we_i && (widx_i == IDX_W'(i));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pb_q <= IDX_W'(i);
            at_q <= ATTR_W'(RST_ATTR);
         end else if (hit) begin
            pb_q <= wpb_i;
            at_q <= wat_i;
         end
      end

      assign pb_arr[i] = pb_q;
      assign at_arr[i] = at_q;
   end

   assign rpb_o = pb_arr[ridx_i];
   assign rat_o = at_arr[ridx_i];

endmodule

// File: rtl/rgn_rsp_reg.sv
module rgn_rsp_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              vld_i,
   input  logic [ADDR_W-1:0] paddr_i,
   input  logic              deny_i,
   input  logic [1:0]        cause_i,
   output logic              vld_o,
   output logic [ADDR_W-1:0] paddr_o,
   output logic              deny_o,
   output logic [1:0]        cause_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_o   <= 1'b0;
         paddr_o <= '0;
         deny_o  <= 1'b0;
         cause_o <= 2'd0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            paddr_o <= paddr_i;
            deny_o  <= deny_i;
            cause_o <= cause_i;
         end
      end
   end

endmodule

// File: rtl/rgn_prot_unit.sv
module rgn_prot_unit
   import rgn_prot_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int IDX_W    = 3,
   parameter int ATTR_W   = 4,
   parameter int RST_ATTR = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_vaddr_i,
   input  logic [1:0]        req_kind_i,
   input  logic              upd_en_i,
   input  logic              upd_tbl_i,
   input  logic [IDX_W-1:0]  upd_idx_i,
   input  logic [IDX_W-1:0]  upd_pbase_i,
   input  logic [ATTR_W-1:0] upd_attr_i,
   output logic [ADDR_W-1:0] lk_paddr_o,
   output logic              lk_deny_o,
   output logic [1:0]        lk_cause_o,
   output logic [2:0]        lk_rights_o,
   output logic [ADDR_W-1:0] pg_size_o,
   output logic              rsp_valid_o,
   output logic [ADDR_W-1:0] rsp_paddr_o,
   output logic              rsp_deny_o,
   output logic [1:0]        rsp_cause_o
);

   localparam int OFS_W = ADDR_W - IDX_W;
   localparam logic [ADDR_W-1:0] PG_BYTES = ADDR_W'(1) << OFS_W;

   generate
      if (IDX_W < 1 || OFS_W < 1) begin : g_bad_geom
         $error("rgn_prot_unit: IDX_W must leave a non-empty offset");
      end
   endgenerate

   logic [IDX_W-1:0]  rd_idx;
   logic [IDX_W-1:0]  tbl_pb [NUM_TBL];
   logic [ATTR_W-1:0] tbl_at [NUM_TBL];

   assign rd_idx = req_vaddr_i[ADDR_W-1 -: IDX_W];

   // one region table per access class, selected by upd_tbl_i on writes
   for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
      logic we;
      assign we = upd_en_i && (upd_tbl_i == 1'(t));

      rgn_table #(
         .IDX_W   (IDX_W),
         .ATTR_W  (ATTR_W),
         .RST_ATTR(RST_ATTR)
      ) u_tbl (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .we_i  (we),
         .widx_i(upd_idx_i),
         .wpb_i (upd_pbase_i),
         .wat_i (upd_attr_i),
         .ridx_i(rd_idx),
         .rpb_o (tbl_pb[t]),
         .rat_o (tbl_at[t])
      );
   end

   acc_kind_e         kind;
   logic              is_fetch;
   logic [IDX_W-1:0]  sel_pb;
   logic [ATTR_W-1:0] sel_at;
   rights_t           rights;
   logic              granted;
   deny_cause_e       cause;

   assign kind     = acc_kind_e'(req_kind_i);
   assign is_fetch = (kind == ACC_FETCH);
   assign sel_pb   = is_fetch ? tbl_pb[TBL_INSTR] : tbl_pb[TBL_DATA];
   assign sel_at   = is_fetch ? tbl_at[TBL_INSTR] : tbl_at[TBL_DATA];

   rgn_attr_decode #(.ATTR_W(ATTR_W)) u_dec (
      .attr_i  (sel_at),
      .rights_o(rights)
   );

   always_comb begin
      unique case (kind)
         ACC_LOAD:  granted = rights.r;
         ACC_STORE: granted = rights.w;
         ACC_FETCH: granted = rights.x;
         default:   granted = 1'b0;
      endcase
   end

   always_comb begin
      if (granted) begin
         cause = CZ_NONE;
      end else begin
         unique case (kind)
            ACC_FETCH: cause = CZ_FETCH;
            ACC_STORE: cause = CZ_STORE;
            default:   cause = CZ_LOAD;
         endcase
      end
   end

   assign lk_paddr_o  = {sel_pb, req_vaddr_i[OFS_W-1:0]};
   assign lk_deny_o   = !granted;
   assign lk_cause_o  = cause;
   assign lk_rights_o = rights;
   assign pg_size_o   = PG_BYTES;

   rgn_rsp_reg #(.ADDR_W(ADDR_W)) u_rsp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (req_valid_i),
      .paddr_i(lk_paddr_o),
      .deny_i (lk_deny_o),
      .cause_i(lk_cause_o),
      .vld_o  (rsp_valid_o),
      .paddr_o(rsp_paddr_o),
      .deny_o (rsp_deny_o),
      .cause_o(rsp_cause_o)
   );

endmodule

// File: rtl/rgn_prot_unit_chk.sv
module rgn_prot_unit_chk #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              req_valid_i,
   input logic [ADDR_W-1:0] req_vaddr_i,
   input logic [1:0]        req_kind_i,
   input logic [ADDR_W-1:0] lk_paddr_o,
   input logic              lk_deny_o,
   input logic [1:0]        lk_cause_o,
   input logic [2:0]        lk_rights_o,
   input logic              rsp_valid_o,
   input logic [ADDR_W-1:0] rsp_paddr_o,
   input logic              rsp_deny_o,
   input logic [1:0]        rsp_cause_o
);

   localparam int OFS_W = ADDR_W - IDX_W;

   // R1
   ofs_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_paddr_o[OFS_W-1:0] == req_vaddr_i[OFS_W-1:0]);

   // R2
   store_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_kind_i == 2'd1 && !lk_deny_o) |-> lk_rights_o[1]);

   // R3
   fetch_right_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_kind_i == 2'd2 && !lk_deny_o) |-> lk_rights_o[2]);

   // R5
   fetch_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_kind_i == 2'd2 && lk_deny_o) |-> lk_cause_o == 2'd1);

   // R5
   store_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_kind_i == 2'd1 && lk_deny_o) |-> lk_cause_o == 2'd3);

   // R10
   rsvd_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_kind_i == 2'd3) |-> (lk_deny_o && lk_cause_o == 2'd2));

   // R8
   rsp_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> rsp_valid_o);

   // R8
   rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> !rsp_valid_o);

   // R8
   rsp_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> (rsp_paddr_o == $past(lk_paddr_o) &&
                       rsp_deny_o == $past(lk_deny_o) &&
                       rsp_cause_o == $past(lk_cause_o)));

   // R8
   rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> ($stable(rsp_paddr_o) && $stable(rsp_deny_o) && $stable(rsp_cause_o)));

endmodule

bind rgn_prot_unit rgn_prot_unit_chk #(
   .ADDR_W(ADDR_W),
   .IDX_W (IDX_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .req_valid_i(req_valid_i),
   .req_vaddr_i(req_vaddr_i),
   .req_kind_i (req_kind_i),
   .lk_paddr_o (lk_paddr_o),
   .lk_deny_o  (lk_deny_o),
   .lk_cause_o (lk_cause_o),
   .lk_rights_o(lk_rights_o),
   .rsp_valid_o(rsp_valid_o),
   .rsp_paddr_o(rsp_paddr_o),
   .rsp_deny_o (rsp_deny_o),
   .rsp_cause_o(rsp_cause_o)
);

// File: tb/rgn_prot_unit_test.sv
module rgn_prot_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        upd_en = 1'b0;
   logic        upd_tbl = 1'b0;
   logic [2:0]  upd_idx = '0;
   logic [2:0]  upd_pbase = '0;
   logic [3:0]  upd_attr = '0;
   logic [31:0] lk_paddr;
   logic        lk_deny;
   logic [1:0]  lk_cause;
   logic [2:0]  lk_rights;
   logic [31:0] pg_size;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_deny;
   logic [1:0]  rsp_cause;

   always #10 clk = ~clk;

   rgn_prot_unit uut (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
      .req_kind_i(req_kind), .upd_en_i(upd_en), .upd_tbl_i(upd_tbl), .upd_idx_i(upd_idx),
      .upd_pbase_i(upd_pbase), .upd_attr_i(upd_attr), .lk_paddr_o(lk_paddr),
      .lk_deny_o(lk_deny), .lk_cause_o(lk_cause), .lk_rights_o(lk_rights),
      .pg_size_o(pg_size), .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
      .rsp_deny_o(rsp_deny), .rsp_cause_o(rsp_cause)
   );

   typedef struct {
      logic [31:0] paddr;
      logic        deny;
      logic [1:0]  cause;
      string       tag;
   } exp_t;

   exp_t        sbq[$];
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 0;
   logic [31:0] last_paddr = '0;
   logic [1:0]  last_cause = '0;

   // bench model: [0] data table, [1] instruction table
   logic [2:0] m_pb [2][8];
   logic [3:0] m_at [2][8];

   task automatic model_reset();
      for (int t = 0; t < 2; t++)
         for (int i = 0; i < 8; i++) begin
            m_pb[t][i] = 3'(i);
            m_at[t][i] = 4'd2;
         end
   endtask

   function automatic logic [2:0] rights_of(logic [3:0] a);
      logic rw, x;
      rw = ((a < 4'd6) && (a != 4'd3)) || (a == 4'd14);
      x  = (a >= 4'd1) && (a <= 4'd5);
      return {x, rw, rw};
   endfunction

   function automatic exp_t predict(logic [31:0] va, logic [1:0] kind, string tag);
      exp_t e;
      int t;
      logic [2:0] r;
      logic ok;
      t = (kind == 2'd2) ? 1 : 0;
      r = rights_of(m_at[t][va[31:29]]);
      ok = (kind == 2'd3) ? 1'b0 : r[kind];
      e.paddr = {m_pb[t][va[31:29]], va[28:0]};
      e.deny  = !ok;
      e.cause = ok ? 2'd0 : (kind == 2'd2 ? 2'd1 : (kind == 2'd1 ? 2'd3 : 2'd2));
      e.tag   = tag;
      return e;
   endfunction

   task automatic check(logic [31:0] act, logic [31:0] exp, string tag, string what);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   // drive one lookup; compare the same-cycle outputs and queue the registered one
   task automatic lookup(logic [31:0] va, logic [1:0] kind, string tag);
      exp_t e;
      @(negedge clk);
      upd_en = 1'b0;
      req_valid = 1'b1;
      req_vaddr = va;
      req_kind = kind;
      #2;
      e = predict(va, kind, tag);
      check(lk_paddr, e.paddr, tag, "lk_paddr");
      check(32'(lk_deny), 32'(e.deny), tag, "lk_deny");
      check(32'(lk_cause), 32'(e.cause), tag, "lk_cause");
      check(32'(lk_rights), 32'(rights_of(m_at[(kind == 2'd2) ? 1 : 0][va[31:29]])), "R11", "lk_rights");
      sbq.push_back(e);
      last_paddr = e.paddr;
      last_cause = e.cause;
   endtask

   // update one region and probe it in the same cycle (old contents expected)
   task automatic upd_probe(logic tbl, logic [2:0] idx, logic [2:0] pb, logic [3:0] at);
      exp_t e;
      logic [31:0] va;
      logic [1:0]  kind;
      va = {idx, 29'h0123_4567};
      kind = tbl ? 2'd2 : 2'd0;
      @(negedge clk);
      upd_en = 1'b1;
      upd_tbl = tbl;
      upd_idx = idx;
      upd_pbase = pb;
      upd_attr = at;
      req_valid = 1'b1;
      req_vaddr = va;
      req_kind = kind;
      #2;
      e = predict(va, kind, "R7");
      check(lk_paddr, e.paddr, "R7", "same-cycle paddr");
      check(32'(lk_cause), 32'(e.cause), "R7", "same-cycle cause");
      sbq.push_back(e);
      last_paddr = e.paddr;
      last_cause = e.cause;
      m_pb[tbl][idx] = pb;
      m_at[tbl][idx] = at;
   endtask

   task automatic idle();
      @(negedge clk);
      upd_en = 1'b0;
      req_valid = 1'b0;
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // monitor: registered results are due one rising edge after the request
   always @(negedge clk) begin
      if (rst_n && !done && rsp_valid) begin
         exp_t e;
         if (sbq.size() == 0) begin
            n_chk++;
            n_err++;
            $display("FAIL R8 unexpected rsp_valid: actual 1 expected 0");
         end else begin
            e = sbq.pop_front();
            check(rsp_paddr, e.paddr, "R8", {"rsp_paddr for ", e.tag});
            check(32'(rsp_deny), 32'(e.deny), "R8", {"rsp_deny for ", e.tag});
            check(32'(rsp_cause), 32'(e.cause), "R8", {"rsp_cause for ", e.tag});
         end
      end
   end

   initial begin
      #(20 * 100000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      report();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check(32'(rsp_valid), 32'd0, "R8", "rsp_valid in reset");
      rst_n = 1'b1;

      // R6 / R1 / R4: identity map after reset, all kinds
      for (int i = 0; i < 8; i++)
         for (int k = 0; k < 4; k++)
            lookup({3'(i), 29'h1ABC_DEF0 ^ 29'(i * 77)}, 2'(k), (k == 3) ? "R10" : "R6");
      check(pg_size, 32'h2000_0000, "R9", "pg_size");

      // R7 / R4: rewrite data region 3 as execute-only, instruction side unaffected
      upd_probe(1'b0, 3'd3, 3'd6, 4'd3);
      lookup({3'd3, 29'h0000_0040}, 2'd0, "R7");
      lookup({3'd3, 29'h1FFF_FFFF}, 2'd1, "R7");
      lookup({3'd3, 29'h0000_0040}, 2'd2, "R4");
      lookup({3'd2, 29'h0000_0040}, 2'd0, "R7");
      upd_probe(1'b1, 3'd0, 3'd5, 4'd15);
      lookup({3'd0, 29'h0000_1000}, 2'd2, "R4");
      lookup({3'd0, 29'h0000_1000}, 2'd0, "R4");

      // R2 / R3 / R5: sweep all attribute codes on region 5 of both tables
      for (int a = 0; a < 16; a++) begin
         upd_probe(1'b0, 3'd5, 3'(7 - (a % 8)), 4'(a));
         upd_probe(1'b1, 3'd5, 3'(a % 8), 4'(a));
         lookup({3'd5, 29'h0765_4321}, 2'd0, "R2");
         lookup({3'd5, 29'h0765_4321}, 2'd1, "R5");
         lookup({3'd5, 29'h0765_4321}, 2'd2, "R3");
         lookup({3'd5, 29'h0765_4321}, 2'd3, "R10");
      end

      // R8: idle cycles keep the last registered result
      idle();
      idle();
      idle();
      #2;
      check(32'(rsp_valid), 32'd0, "R8", "rsp_valid idle");
      check(rsp_paddr, last_paddr, "R8", "rsp_paddr held");
      check(32'(rsp_cause), 32'(last_cause), "R8", "rsp_cause held");

      // R6: a second reset restores identity with attribute 2
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      #2;
      check(32'(rsp_valid), 32'd0, "R6", "rsp_valid after reset");
      @(negedge clk);
      rst_n = 1'b1;
      lookup({3'd3, 29'h0000_0040}, 2'd1, "R6");
      lookup({3'd5, 29'h0000_0040}, 2'd2, "R6");
      lookup({3'd0, 29'h0000_1000}, 2'd2, "R6");
      idle();
      idle();
      check(32'(sbq.size()), 32'd0, "R8", "queue drained");
      done = 1;
      report();
   end

endmodule